// File: doc/BRIEF.md
# Software-Refilled Fully Associative Translation Cache

This block caches a handful of page translations for one requester. Each slot keeps a virtual page number, the physical frame it maps to, and three flags: execute-allowed, write-allowed and valid. A request carries a virtual address and an access kind. The page-number field of the request is compared against every slot in the same cycle. When a valid slot matches and the access kind is allowed, the block returns the stored frame joined to the unchanged page offset. Otherwise it reports a fault, and software resolves the fault.

The hardware never walks page tables and never refills itself. Software writes slots with an insert command and clears every slot at once with a flush command, for example on a process switch. A write that hits a slot whose write flag is clear also faults. This lets software share a page read-only and copy it on the first write. An insert for a page that is already cached overwrites that slot in place. An insert for a new page replaces the slot chosen by a round-robin pointer.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is invalid, the round-robin pointer selects slot 0, and `rsp_valid`, `rsp_hit`, `rsp_fault` and `rsp_paddr` are all zero.
- R2: A request presented in cycle t is answered in cycle t+1 with `rsp_valid`=1. In a cycle after no request, `rsp_valid`, `rsp_hit` and `rsp_fault` are 0.
- R3: If the request's page number (address bits [31:12]) matches a valid slot and the access is allowed, the response has `rsp_hit`=1, `rsp_fault`=0 and `rsp_paddr` = {stored frame, request bits [11:0]}.
- R4: If no valid slot matches, the response has `rsp_hit`=0, `rsp_fault`=1 and `rsp_paddr`=0.
- R5: The access kind is encoded as 2'b01 for write. A write that matches a valid slot with its write flag clear gives `rsp_hit`=1, `rsp_fault`=1 and `rsp_paddr`=0. With the write flag set, the write succeeds as in R3.
- R6: The access kind is encoded as 2'b10 for execute. An execute that matches a slot with its execute flag clear faults the same way as R5. Kinds 2'b00 and 2'b11 are reads and need only the valid flag.
- R7: An insert whose page number equals that of a valid slot rewrites that slot and leaves the round-robin pointer unchanged.
- R8: Any other insert writes the slot the pointer selects. The pointer then advances by one and wraps from ENTRIES-1 to 0.
- R9: A flush invalidates every slot and returns the pointer to 0. A flush takes priority over an insert in the same cycle, and that insert is dropped.
- R10: An insert with its valid flag clear into a matching slot removes only that page. Later lookups of that page miss, and other pages are unaffected.
- R11: A lookup in the same cycle as an insert or flush is answered from the slot contents that were in place before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 read |
| req_vaddr | input | 32 | Virtual address: page number [31:12], offset [11:0] |
| ins_valid | input | 1 | Insert command strobe |
| ins_vpn | input | 20 | Page number to insert |
| ins_pfn | input | 20 | Frame number to insert |
| ins_x | input | 1 | Execute-allowed flag of the inserted slot |
| ins_w | input | 1 | Write-allowed flag of the inserted slot |
| ins_v | input | 1 | Valid flag of the inserted slot |
| flush | input | 1 | Invalidate all slots and reset the pointer |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_hit | output | 1 | A valid slot matched the request |
| rsp_fault | output | 1 | Miss or access not allowed |
| rsp_paddr | output | 32 | Translated address, zero on fault |

## Verification
Every lookup result is due exactly one clock edge after its request. The bench drives each request on a falling edge and reads `rsp_*` on the next falling edge, after the single response register has loaded. Insert and flush commands take effect on the edge that ends their cycle. The bench therefore applies them one cycle before the lookups that depend on them. The exception is the deliberate same-cycle cases, where the expected result is taken from the bench's model before the model is updated. Slot and pointer state is seen only through later lookups. Evictions are predicted by a model of the round-robin pointer in the bench.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_READ2 = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic x;
    logic w;
    logic v;
  } perm_t;

endpackage

// File: rtl/xlat_victim.sv
`timescale 1ns/1ps
module xlat_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);

  logic [IDX_W-1:0] ptr_d;
  logic             ptr_en;

  assign ptr_en = clr | adv;

  always_comb begin
    if (clr) begin
      ptr_d = '0;
    end else if (ptr == IDX_W'(ENTRIES - 1)) begin
      ptr_d = '0;
    end else begin
      ptr_d = ptr + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ptr_en) begin
      ptr <= ptr_d;
    end
  end

endmodule

// File: rtl/xlat_store.sv
`timescale 1ns/1ps
module xlat_store
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PFN_W-1:0]   wr_pfn,
  input  perm_t              wr_perm,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic [ENTRIES-1:0] lk_match,
  output logic [ENTRIES-1:0] wr_match,
  output logic [PFN_W-1:0]   lk_pfn,
  output perm_t              lk_perm,
  output logic [ENTRIES-1:0] valid_vec
);

  logic [VPN_W-1:0] vpn_q [ENTRIES];
  logic [PFN_W-1:0] pfn_q [ENTRIES];
  perm_t            perm_q [ENTRIES];
  logic [VPN_W-1:0] vpn_d [ENTRIES];
  logic [PFN_W-1:0] pfn_d [ENTRIES];
  perm_t            perm_d [ENTRIES];
  logic [ENTRIES-1:0] slot_en;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign valid_vec[g] = perm_q[g].v;
    assign lk_match[g]  = perm_q[g].v && (vpn_q[g] == lk_vpn);
    assign wr_match[g]  = perm_q[g].v && (vpn_q[g] == wr_vpn);
    assign slot_en[g]   = clr || (wr_en && (wr_idx == IDX_W'(g)));
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (clr) begin
        vpn_d[i]  = vpn_q[i];
        pfn_d[i]  = pfn_q[i];
        perm_d[i] = '0;
      end else begin
        vpn_d[i]  = wr_vpn;
        pfn_d[i]  = wr_pfn;
        perm_d[i] = wr_perm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]  <= '0;
        pfn_q[i]  <= '0;
        perm_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (slot_en[i]) begin
          vpn_q[i]  <= vpn_d[i];
          pfn_q[i]  <= pfn_d[i];
          perm_q[i] <= perm_d[i];
        end
      end
    end
  end

  always_comb begin
    lk_pfn  = '0;
    lk_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_pfn  = lk_pfn | ({PFN_W{lk_match[i]}} & pfn_q[i]);
      lk_perm = lk_perm | ({$bits(perm_t){lk_match[i]}} & perm_q[i]);
    end
  end

endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int PA_W  = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             ins_valid,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PFN_W-1:0] ins_pfn,
  input  logic             ins_x,
  input  logic             ins_w,
  input  logic             ins_v,
  input  logic             flush,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr
);

  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] ins_match;
  logic [ENTRIES-1:0] valid_vec;
  logic [PFN_W-1:0]   lk_pfn;
  perm_t              lk_perm;
  perm_t              ins_perm;
  logic [IDX_W-1:0]   victim_ptr;
  logic [IDX_W-1:0]   match_idx;
  logic [IDX_W-1:0]   wr_idx;
  logic               ins_hit;
  logic               ins_go;
  logic               victim_adv;

  assign ins_perm = '{x: ins_x, w: ins_w, v: ins_v};
  assign ins_go   = ins_valid && !flush;
  assign ins_hit  = |ins_match;

  always_comb begin
    match_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ins_match[i]) match_idx = match_idx | IDX_W'(i);
    end
  end

  assign wr_idx     = ins_hit ? match_idx : victim_ptr;
  assign victim_adv = ins_go && !ins_hit;

  xlat_store #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (flush),
    .wr_en     (ins_go),
    .wr_idx    (wr_idx),
    .wr_vpn    (ins_vpn),
    .wr_pfn    (ins_pfn),
    .wr_perm   (ins_perm),
    .lk_vpn    (req_vaddr[VA_W-1:OFF_W]),
    .lk_match  (lk_match),
    .wr_match  (ins_match),
    .lk_pfn    (lk_pfn),
    .lk_perm   (lk_perm),
    .valid_vec (valid_vec)
  );

  xlat_victim #(
    .ENTRIES (ENTRIES)
  ) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (flush),
    .adv   (victim_adv),
    .ptr   (victim_ptr)
  );

  logic            hit_c;
  logic            allow_c;
  logic            fault_c;
  logic [PA_W-1:0] paddr_c;

  always_comb begin
    unique case (acc_kind_e'(req_kind))
      ACC_WRITE: allow_c = lk_perm.w;
      ACC_EXEC:  allow_c = lk_perm.x;
      default:   allow_c = 1'b1;
    endcase
    hit_c   = req_valid && (|lk_match);
    fault_c = req_valid && !(hit_c && allow_c);
    paddr_c = (hit_c && allow_c) ? {lk_pfn, req_vaddr[OFF_W-1:0]} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= hit_c;
      rsp_fault <= fault_c;
      rsp_paddr <= paddr_c;
    end
  end

endmodule

// File: rtl/xlat_cache_chk.sv
`timescale 1ns/1ps
module xlat_cache_chk #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int PA_W  = PFN_W + OFF_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [VA_W-1:0]    req_vaddr,
  input logic               ins_valid,
  input logic               flush,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_fault,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic [ENTRIES-1:0] lk_match,
  input logic [ENTRIES-1:0] ins_match,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [IDX_W-1:0]   victim_ptr
);

  assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0 && victim_ptr == '0));

  assert_resp_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_fault));

  assert_fault_zero_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_paddr == '0));

  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |->
      (rsp_hit && rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !flush && ins_match == '0) |=>
      (victim_ptr == (($past(victim_ptr) == IDX_W'(ENTRIES - 1)) ? '0
                      : $past(victim_ptr) + IDX_W'(1))));

  assert_inplace_keeps_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !flush && ins_match != '0) |=> $stable(victim_ptr));

endmodule

bind xlat_cache xlat_cache_chk #(
  .ENTRIES (ENTRIES),
  .VPN_W   (VPN_W),
  .PFN_W   (PFN_W),
  .OFF_W   (OFF_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_vaddr  (req_vaddr),
  .ins_valid  (ins_valid),
  .flush      (flush),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_fault  (rsp_fault),
  .rsp_paddr  (rsp_paddr),
  .lk_match   (lk_match),
  .ins_match  (ins_match),
  .valid_vec  (valid_vec),
  .victim_ptr (victim_ptr)
);

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [31:0] req_vaddr;
  logic        ins_valid;
  logic [19:0] ins_vpn;
  logic [19:0] ins_pfn;
  logic        ins_x, ins_w, ins_v;
  logic        flush;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_paddr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [19:0] m_vpn [N];
  logic [19:0] m_pfn [N];
  logic        m_x [N];
  logic        m_w [N];
  logic        m_v [N];
  int          m_ptr;

  always #5 clk = ~clk;

  xlat_cache i_xlat_cache (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_vaddr (req_vaddr),
    .ins_valid (ins_valid),
    .ins_vpn   (ins_vpn),
    .ins_pfn   (ins_pfn),
    .ins_x     (ins_x),
    .ins_w     (ins_w),
    .ins_v     (ins_v),
    .flush     (flush),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act cycle %0d exp finish earlier", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act hit/fault/paddr=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_lookup(input logic [31:0] va, input logic [1:0] kind,
                              output logic [33:0] res);
    logic hit, ok;
    logic [19:0] pfn;
    hit = 1'b0; ok = 1'b0; pfn = '0;
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && m_vpn[i] == va[31:12]) begin
        hit = 1'b1;
        pfn = m_pfn[i];
        ok  = (kind == 2'b01) ? m_w[i] : (kind == 2'b10) ? m_x[i] : 1'b1;
      end
    end
    res = {hit, !(hit && ok), (hit && ok) ? {pfn, va[11:0]} : 32'h0};
  endtask

  task automatic model_insert(input logic [19:0] vpn, input logic [19:0] pfn,
                              input logic x, input logic w, input logic v);
    int idx;
    idx = -1;
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) idx = i;
    if (idx < 0) begin
      idx = m_ptr;
      m_ptr = (m_ptr + 1) % N;
    end
    m_vpn[idx] = vpn; m_pfn[idx] = pfn;
    m_x[idx] = x; m_w[idx] = w; m_v[idx] = v;
  endtask

  task automatic model_flush();
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    m_ptr = 0;
  endtask

  task automatic lookup(input string tag, input logic [31:0] va, input logic [1:0] kind);
    logic [33:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_vaddr = va;
    model_lookup(va, kind, exp);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R2 valid"}, {33'h0, rsp_valid}, 34'h1);
    chk(tag, {rsp_hit, rsp_fault, rsp_paddr}, exp);
  endtask

  task automatic insert(input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic x, input logic w, input logic v);
    @(negedge clk);
    ins_valid = 1'b1; ins_vpn = vpn; ins_pfn = pfn;
    ins_x = x; ins_w = w; ins_v = v;
    model_insert(vpn, pfn, x, w, v);
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  function automatic logic [19:0] vpn_of(int i);
    return 20'h10000 + 20'(i * 'h123);
  endfunction

  function automatic logic [19:0] pfn_of(int i);
    return 20'hA0000 ^ 20'(i * 'h0F1 + 7);
  endfunction

  initial begin
    logic [33:0] exp;
    rst_n = 1'b0;
    req_valid = 1'b0; req_kind = 2'b00; req_vaddr = '0;
    ins_valid = 1'b0; ins_vpn = '0; ins_pfn = '0;
    ins_x = 1'b0; ins_w = 1'b0; ins_v = 1'b0;
    flush = 1'b0;
    model_flush();
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = '0; m_pfn[i] = '0; m_x[i] = 0; m_w[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {rsp_hit, rsp_fault, rsp_paddr}, 34'h0);
    chk("R1 reset valid", {33'h0, rsp_valid}, 34'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 idle quiet", {rsp_valid, rsp_hit, rsp_fault, 31'h0}, 34'h0);
    lookup("R1 empty miss vpn0", 32'h0000_0000, 2'b00);
    lookup("R4 empty miss", {vpn_of(0), 12'h321}, 2'b00);

    // fill all slots; flags follow slot index: w = bit0, x = bit1
    for (int i = 0; i < N; i++) insert(vpn_of(i), pfn_of(i), i[1], i[0], 1'b1);

    // sweep every slot with every access kind and two offsets (R3, R5, R6)
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 4; k++)
        for (int o = 0; o < 2; o++)
          lookup($sformatf("R3/R5/R6 slot %0d kind %0d", i, k),
                 {vpn_of(i), 12'(o * 'hFFF + i * 'h11)}, 2'(k));
    lookup("R4 miss neighbour page", {vpn_of(N), 12'h0AB}, 2'b00);

    // ninth insert evicts slot 0 (pointer wrapped from 7)
    insert(20'h77777, 20'h12345, 1'b1, 1'b1, 1'b1);
    lookup("R8 evicted page misses", {vpn_of(0), 12'h004}, 2'b00);
    lookup("R8 new page hits", {20'h77777, 12'hABC}, 2'b01);

    // in-place rewrite of slot 3 keeps pointer at 1
    insert(vpn_of(3), 20'h0BEEF, 1'b0, 1'b0, 1'b1);
    lookup("R7 rewritten frame", {vpn_of(3), 12'h5A5}, 2'b00);
    lookup("R7 rewritten write flag", {vpn_of(3), 12'h5A5}, 2'b01);
    insert(20'h55555, 20'h66666, 1'b0, 1'b1, 1'b1);
    lookup("R8 pointer evicts slot 1", {vpn_of(1), 12'h010}, 2'b00);
    lookup("R7 slot 2 untouched", {vpn_of(2), 12'h020}, 2'b10);
    lookup("R8 second new page", {20'h55555, 12'h001}, 2'b01);

    // single invalidation
    insert(vpn_of(4), 20'h0, 1'b0, 1'b0, 1'b0);
    lookup("R10 removed page misses", {vpn_of(4), 12'h044}, 2'b00);
    lookup("R10 other page intact", {vpn_of(5), 12'h055}, 2'b01);

    // R11 lookup concurrent with insert sees old contents
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b00; req_vaddr = {20'h33333, 12'h123};
    ins_valid = 1'b1; ins_vpn = 20'h33333; ins_pfn = 20'h44444;
    ins_x = 1'b1; ins_w = 1'b1; ins_v = 1'b1;
    model_lookup(req_vaddr, 2'b00, exp);
    model_insert(20'h33333, 20'h44444, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    req_valid = 1'b0; ins_valid = 1'b0;
    chk("R11 lookup with insert uses old state", {rsp_hit, rsp_fault, rsp_paddr}, exp);
    lookup("R11 insert visible next cycle", {20'h33333, 12'h321}, 2'b00);

    // R9 flush with same-cycle insert and lookup
    @(negedge clk);
    flush = 1'b1;
    req_valid = 1'b1; req_kind = 2'b00; req_vaddr = {vpn_of(5), 12'h0F0};
    ins_valid = 1'b1; ins_vpn = 20'h99999; ins_pfn = 20'h11111;
    ins_x = 1'b1; ins_w = 1'b1; ins_v = 1'b1;
    model_lookup(req_vaddr, 2'b00, exp);
    model_flush();
    @(negedge clk);
    flush = 1'b0; req_valid = 1'b0; ins_valid = 1'b0;
    chk("R11 lookup with flush uses old state", {rsp_hit, rsp_fault, rsp_paddr}, exp);
    lookup("R9 flushed page misses", {vpn_of(5), 12'h0F0}, 2'b00);
    lookup("R9 dropped insert misses", {20'h99999, 12'h000}, 2'b00);

    // pointer back at 0: fill N+1 pages, first is evicted
    for (int i = 0; i <= N; i++) insert(vpn_of(i + 20), pfn_of(i + 20), 1'b1, 1'b1, 1'b1);
    lookup("R9 pointer reset evicts first", {vpn_of(20), 12'h001}, 2'b00);
    lookup("R9 second kept", {vpn_of(21), 12'h002}, 2'b10);
    lookup("R8 wrapped insert hits", {vpn_of(20 + N), 12'h003}, 2'b01);

    @(negedge clk);
    chk("R2 idle after traffic", {rsp_valid, rsp_hit, rsp_fault, 31'h0}, 34'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule